// File: doc/BRIEF.md
# Data Watchpoint Address Comparator

The block keeps a small bank of programmable data watchpoints and checks every memory access presented to it against all of them at once. Each watchpoint has two registers: a value register that holds the watched address, and a control register that holds an enable bit, a direction selector, a byte-select bitmap and a mask exponent. Software, or a debug agent, loads the registers through a single write port, with one write per register.

For every access strobe the block gets the start address, the byte length and the direction. On the next clock edge it reports whether any enabled watchpoint overlaps the accessed bytes, along with the index of the lowest-numbered watchpoint that does. The watched range is a naturally aligned power-of-two region when the mask exponent is nonzero. When the exponent is zero, the range is a short run of bytes picked out by the byte-select bitmap. Reserved and malformed encodings resolve to fixed outcomes, so a given register image always has one defined behaviour.

Top module: `wp_comparator`

## Requirements
- R1: After reset every control register reads as zero. A watchpoint whose enable bit (control bit 0) is clear never produces a hit.
- R2: The direction field, control bits [2:1], selects what matches. 0 is reserved and matches nothing, 1 matches reads only (acc_write_i=0), 2 matches writes only, and 3 matches both.
- R3: A mask exponent (control bits [15:11]) of 1 or 2 is reserved, and the watchpoint then never hits.
- R4: A mask exponent M of 3 or more makes the watchpoint cover the 2^M-byte region aligned to 2^M that contains the value register. Set bits in the low M bits of the value register do not prevent a match.
- R5: When the mask exponent is nonzero, the byte-select bitmap (control bits [10:3]) has no effect on matching.
- R6: When the mask exponent is zero and value register bit 2 is set, only bitmap bits [3:0] are used and bits [7:4] are treated as zero.
- R7: When the mask exponent is zero and the effective bitmap is zero, the watchpoint never hits.
- R8: When the mask exponent is zero, the watched bytes start at the value register plus the index of the lowest set bitmap bit. They extend for the length of the unbroken run of ones that begins there. Set bits above that run are ignored.
- R9: An access hits a watchpoint when the bytes [addr, addr+len) overlap its watched range and the direction matches. An access of length 0 never hits.
- R10: hit_o and hit_idx_o are updated on the clock edge that samples acc_valid_i high. They reflect that access for one cycle, and hit_o is low in any cycle that follows an edge where acc_valid_i was low.
- R11: When several watchpoints hit, hit_idx_o gives the lowest index among them.
- R12: A write with wr_ctrl_i=1 loads the low 16 bits of wr_data_i into the control register of watchpoint wr_idx_i. A write with wr_ctrl_i=0 loads all of wr_data_i into its value register. The new contents apply to accesses sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_ctrl_i | input | 1 | 1 selects the control register, 0 selects the value register |
| wr_idx_i | input | IDX_W (2) | Watchpoint index for the write |
| wr_data_i | input | ADDR_W (64) | Write data |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W (64) | Access start address |
| acc_len_i | input | LEN_W (4) | Access length in bytes |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| hit_o | output | 1 | Registered hit flag |
| hit_idx_o | output | IDX_W (2) | Lowest matching watchpoint index |

## Verification
The assertions assume that rst_ni is released away from active traffic. They also assume that an access's byte range and a watched range never wrap past the top of the 64-bit address space. The comparison is carried out one bit wider so that such a wrap counts as no overlap rather than an aliased match. The stimulus keeps every access in low memory and drives each request for exactly one cycle. It changes registers only between accesses, which keeps the causal relation between the sampled request and the registered hit unambiguous. The sweeps exercise every bitmap value with value bit 2 both clear and set, mask exponents from 0 to 12, every direction code, access lengths from 0 to 8, and all enable subsets of four overlapping watchpoints.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CTRL_W   = 16;
  localparam int EN_BIT   = 0;
  localparam int DIR_LSB  = 1;
  localparam int SEL_LSB  = 3;
  localparam int SEL_W    = 8;
  localparam int MEXP_LSB = 11;
  localparam int MEXP_W   = 5;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_LOAD  = 2'd1,
    DIR_STORE = 2'd2,
    DIR_ANY   = 2'd3
  } dir_e;
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] value_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              valid_o,
  output logic              ld_ok_o,
  output logic              st_ok_o,
  output logic [ADDR_W:0]   lo_o,
  output logic [ADDR_W:0]   hi_o
);
  localparam int ST_W  = $clog2(SEL_W);
  localparam int RUN_W = $clog2(SEL_W + 1);

  dir_e              dir;
  logic [MEXP_W-1:0] mexp;
  logic [SEL_W-1:0]  sel;
  logic [ST_W-1:0]   start;
  logic [RUN_W-1:0]  run;
  logic              found, done;
  logic [ADDR_W:0]   span;

  assign dir     = dir_e'(ctrl_i[DIR_LSB +: 2]);
  assign mexp    = ctrl_i[MEXP_LSB +: MEXP_W];
  assign ld_ok_o = (dir == DIR_LOAD)  || (dir == DIR_ANY);
  assign st_ok_o = (dir == DIR_STORE) || (dir == DIR_ANY);

  // word-aligned value narrows the bitmap to its low nibble
  always_comb begin
    sel = ctrl_i[SEL_LSB +: SEL_W];
    if (value_i[2]) sel[SEL_W-1:4] = '0;
  end

  // first run of ones in the bitmap
  always_comb begin
    start = '0;
    run   = '0;
    found = 1'b0;
    done  = 1'b0;
    for (int i = 0; i < SEL_W; i++) begin
      if (!found && sel[i]) begin
        found = 1'b1;
        start = ST_W'(i);
      end
      if (found && !done) begin
        if (sel[i]) run = run + RUN_W'(1);
        else        done = 1'b1;
      end
    end
  end

  assign span = (ADDR_W+1)'(1) << mexp;

  always_comb begin
    valid_o = ctrl_i[EN_BIT] && (dir != DIR_NONE);
    lo_o    = '0;
    hi_o    = '0;
    if (mexp == MEXP_W'(1) || mexp == MEXP_W'(2)) begin
      valid_o = 1'b0;
    end else if (mexp != '0) begin
      lo_o = {1'b0, value_i & ~(span[ADDR_W-1:0] - ADDR_W'(1))};
      hi_o = lo_o + span;
    end else begin
      if (!found) valid_o = 1'b0;
      lo_o = {1'b0, value_i} + (ADDR_W+1)'(start);
      hi_o = lo_o + (ADDR_W+1)'(run);
    end
  end
endmodule

// File: rtl/wp_match.sv
module wp_match #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              valid_i,
  input  logic              ld_ok_i,
  input  logic              st_ok_i,
  input  logic [ADDR_W:0]   lo_i,
  input  logic [ADDR_W:0]   hi_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              acc_write_i,
  output logic              match_o
);
  logic [ADDR_W:0] a_lo, a_hi;
  logic            dir_ok, overlap;

  assign a_lo    = {1'b0, acc_addr_i};
  assign a_hi    = a_lo + (ADDR_W+1)'(acc_len_i);
  assign dir_ok  = acc_write_i ? st_ok_i : ld_ok_i;
  assign overlap = (acc_len_i != '0) && (a_lo < hi_i) && (lo_i < a_hi);
  assign match_o = valid_i && dir_ok && overlap;
endmodule

// File: rtl/wp_prio.sv
module wp_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/wp_comparator.sv
module wp_comparator
  import wp_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4,
  localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_ctrl_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              acc_write_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [ADDR_W-1:0] value_q [NUM_WP];
  logic [CTRL_W-1:0] ctrl_q  [NUM_WP];
  logic [NUM_WP-1:0] match_vec, en_vec, ld_vec, st_vec, rsv_vec;
  logic              any_match;
  logic [IDX_W-1:0]  first_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WP; i++) begin
        value_q[i] <= '0;
        ctrl_q[i]  <= '0;
      end
    end else if (wr_en_i && (int'(wr_idx_i) < NUM_WP)) begin
      if (wr_ctrl_i) ctrl_q[wr_idx_i]  <= wr_data_i[CTRL_W-1:0];
      else           value_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic            valid, ld_ok, st_ok;
    logic [ADDR_W:0] lo, hi;

    wp_decode #(.ADDR_W(ADDR_W)) u_dec (
      .value_i (value_q[g]),
      .ctrl_i  (ctrl_q[g]),
      .valid_o (valid),
      .ld_ok_o (ld_ok),
      .st_ok_o (st_ok),
      .lo_o    (lo),
      .hi_o    (hi)
    );

    wp_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cmp (
      .valid_i     (valid),
      .ld_ok_i     (ld_ok),
      .st_ok_i     (st_ok),
      .lo_i        (lo),
      .hi_i        (hi),
      .acc_addr_i  (acc_addr_i),
      .acc_len_i   (acc_len_i),
      .acc_write_i (acc_write_i),
      .match_o     (match_vec[g])
    );

    assign en_vec[g]  = ctrl_q[g][EN_BIT];
    assign ld_vec[g]  = ctrl_q[g][DIR_LSB];
    assign st_vec[g]  = ctrl_q[g][DIR_LSB+1];
    assign rsv_vec[g] = (ctrl_q[g][MEXP_LSB +: MEXP_W] == MEXP_W'(1)) ||
                        (ctrl_q[g][MEXP_LSB +: MEXP_W] == MEXP_W'(2));
  end

  wp_prio #(.N(NUM_WP), .IDX_W(IDX_W)) u_prio (
    .req_i (match_vec),
    .any_o (any_match),
    .idx_o (first_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= acc_valid_i && any_match;
      hit_idx_o <= acc_valid_i ? first_idx : '0;
    end
  end

  p_hit_after_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(acc_valid_i));

  p_hit_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> 1'($past(en_vec) >> hit_idx_o));

  p_hit_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(acc_write_i) ? 1'($past(st_vec) >> hit_idx_o)
                                  : 1'($past(ld_vec) >> hit_idx_o)));

  p_hit_mask_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !1'($past(rsv_vec) >> hit_idx_o));

  p_lowest_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (1'($past(match_vec) >> hit_idx_o) &&
               (($past(match_vec) & ((NUM_WP'(1) << hit_idx_o) - NUM_WP'(1))) == '0)));

  p_miss_consistent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_o && $past(acc_valid_i)) |-> ($past(match_vec) == '0));
endmodule

// File: tb/sim_wp_comparator.sv
module sim_wp_comparator;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_ctrl = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [3:0]  acc_len = '0;
  logic        hit;
  logic [1:0]  hit_idx;

  logic [63:0] sh_val [NW];
  logic [15:0] sh_ctl [NW];

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_comparator u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ctrl_i(wr_ctrl),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_len_i(acc_len), .acc_write_i(acc_write),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  function automatic bit ref_hit(int k, logic [63:0] a, int len, bit w);
    logic [15:0] c = sh_ctl[k];
    logic [63:0] v = sh_val[k];
    int m = int'(c[15:11]);
    int b = int'(c[10:3]);
    logic [64:0] lo, hi, alo, ahi;
    if (!c[0]) return 0;
    if (c[2:1] == 2'd0) return 0;
    if (w && !c[2]) return 0;
    if (!w && !c[1]) return 0;
    if (m == 1 || m == 2) return 0;
    if (len == 0) return 0;
    if (m != 0) begin
      lo = {1'b0, v} - ({1'b0, v} % (65'd1 << m));
      hi = lo + (65'd1 << m);
    end else begin
      int s = 0, n = 0;
      if (v[2]) b = b % 16;
      if (b == 0) return 0;
      while (((b >> s) & 1) == 0) s++;
      while (s + n < 8 && ((b >> (s + n)) & 1) == 1) n++;
      lo = {1'b0, v} + 65'(s);
      hi = lo + 65'(n);
    end
    alo = {1'b0, a};
    ahi = alo + 65'(len);
    return (alo < hi) && (lo < ahi);
  endfunction

  task automatic wr(int k, bit is_ctl, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_ctrl = is_ctl; wr_idx = 2'(k); wr_data = d;
    if (is_ctl) sh_ctl[k] = d[15:0]; else sh_val[k] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk(string tag, bit got_h, int got_i, bit exp_h, int exp_i);
    n_vec++;
    if (got_h !== exp_h || (exp_h && got_i != exp_i)) begin
      n_bad++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, got_h, got_i, exp_h, exp_i);
    end
  endtask

  task automatic acc(string tag, logic [63:0] a, int len, bit w);
    bit eh = 0;
    int ei = 0;
    for (int k = NW - 1; k >= 0; k--)
      if (ref_hit(k, a, len, w)) begin eh = 1; ei = k; end
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_len = 4'(len); acc_write = w;
    @(negedge clk);
    acc_valid = 0;
    chk(tag, hit, int'(hit_idx), eh, ei);
  endtask

  task automatic clear_all();
    for (int k = 0; k < NW; k++) wr(k, 1, 64'd0);
  endtask

  initial begin
    for (int k = 0; k < NW; k++) begin sh_val[k] = '0; sh_ctl[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, all disabled
    chk("R1 reset", hit, int'(hit_idx), 0, 0);
    acc("R1 after reset", 64'h0, 8, 0);
    acc("R1 after reset", 64'h0, 8, 1);

    // R8/R7/R6: full bitmap sweep, value bit2 clear and set
    for (int vsel = 0; vsel < 2; vsel++) begin
      wr(0, 0, vsel ? 64'h104 : 64'h100);
      for (int b = 0; b < 256; b++) begin
        wr(0, 1, 64'((b << 3) | (3 << 1) | 1));
        for (int a = 'h0FE; a < 'h10E; a++)
          acc(vsel ? "R6 bitmap nibble" : (b == 0 ? "R7 empty bitmap" : "R8 first run"),
              64'(a), 1, a[0]);
      end
    end
    // R1: enable clear with valid fields
    wr(0, 0, 64'h100);
    wr(0, 1, 64'((8'hFF << 3) | (3 << 1)));
    for (int a = 'h100; a < 'h108; a++) acc("R1 enable clear", 64'(a), 1, 0);

    // R2: direction codes
    for (int d = 0; d < 4; d++) begin
      wr(0, 1, 64'((8'hFF << 3) | (d << 1) | 1));
      acc("R2 direction load", 64'h103, 2, 0);
      acc("R2 direction store", 64'h103, 2, 1);
    end

    // R3/R4/R5: mask exponents with stray low value bits and bitmap both ways
    for (int m = 0; m <= 12; m++) begin
      for (int bz = 0; bz < 2; bz++) begin
        logic [63:0] base = 64'h10000;
        logic [63:0] sz = 64'd1 << m;
        wr(0, 0, base | ((sz - 1) & 64'h5A5));
        wr(0, 1, 64'((m << 11) | ((bz ? 8'h00 : 8'h81) << 3) | (3 << 1) | 1));
        acc(m == 1 || m == 2 ? "R3 reserved mask" : "R4 below region", base - 1, 1, 0);
        acc(m == 1 || m == 2 ? "R3 reserved mask" : "R4 region start", base, 1, 1);
        acc(m == 1 || m == 2 ? "R3 reserved mask" : "R5 region last", base + sz - 1, 1, 0);
        acc(m == 1 || m == 2 ? "R3 reserved mask" : "R4 past region", base + sz, 1, 1);
        acc("R5 straddle start", base - 2, 4, 0);
      end
    end

    // R9: length sweep around a 4-byte watched window
    wr(0, 0, 64'h200);
    wr(0, 1, 64'((8'h3C << 3) | (3 << 1) | 1));
    for (int a = 'h1F8; a < 'h20A; a++)
      for (int l = 0; l <= 8; l++) acc("R9 overlap", 64'(a), l, 0);

    // R10: idle cycle after a hit
    acc("R10 hit", 64'h202, 1, 0);
    @(negedge clk);
    chk("R10 idle after hit", hit, int'(hit_idx), 0, 0);

    // R11: overlapping watchpoints, every enable subset
    for (int k = 0; k < NW; k++) wr(k, 0, 64'h300 + 64'(k));
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < NW; k++)
        wr(k, 1, 64'((((s >> k) & 1)) | (3 << 1) | (8'h01 << 3)));
      acc("R11 lowest index", 64'h300, 4, 0);
      acc("R11 lowest index", 64'h302, 2, 1);
    end

    // R12: value write changes the match, control write ignores high data bits
    clear_all();
    wr(2, 0, 64'h400);
    wr(2, 1, 64'hFFFF_0000_0000_0000 | 64'((8'h01 << 3) | (1 << 1) | 1));
    acc("R12 control low bits", 64'h400, 1, 0);
    wr(2, 0, 64'h480);
    acc("R12 old value gone", 64'h400, 1, 0);
    acc("R12 new value", 64'h480, 1, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule